// File: doc/BRIEF.md
# Virtual Message Queue Translator

This block sits inside a network interface and translates message addresses in both directions. An outgoing message header names a virtual destination index rather than a physical node. A lookup table turns that index into a physical node number and a virtual receive-queue identifier, and these are handed to the injection logic one cycle later. If the table entry is not valid, the message is dropped and a protection-error pulse is raised instead.

An incoming message names a virtual receive queue, one of up to 512 logical queues. A second table decides where the message goes. If the entry is valid and marked resident, the message is steered to one of a small set of hardware queues (16 by default), identified by a 4-bit index. Otherwise it is diverted to the service-processor path, which emulates the queue in software. Both directions can be remapped at any time through privileged configuration write ports. A queue can therefore move between hardware and software without the applications that send to it or receive from it being aware of the move. Each table write is seen by the first lookup in a later cycle.

The receive side accepts one message at a time through a valid/ready handshake. It holds a message at its output while the chosen hardware queue reports full, or while the software path withholds ready.

Top module: `msgq_translate`

## Requirements
- R1: While reset is high, and in the cycle after it, `tx_out_valid`, `tx_err`, `rx_hw_valid` and `rx_sw_valid` are low and `rx_in_ready` is high. A reset also discards a receive message that is waiting at the output.
- R2: A transmit lookup of a valid entry presented in cycle N gives `tx_out_valid`=1 in cycle N+1, together with that entry's node, its virtual receive queue, and the tag that came in with the header.
- R3: A transmit lookup of an invalid entry gives `tx_err`=1 for one cycle in cycle N+1 and `tx_out_valid`=0. The message is never injected, and `tx_err` and `tx_out_valid` are never high together.
- R4: A transmit-table write in cycle N is not seen by a lookup in cycle N, which returns the old entry. It is seen by a lookup in cycle N+1 or later.
- R5: A received message whose entry has valid=1 and resident=1 appears one cycle after acceptance on `rx_hw_valid`, with `rx_hw_q` equal to the entry's 4-bit hardware-queue index and `rx_out_tag` equal to the message tag.
- R6: A received message whose entry has resident=0 or valid=0 appears on `rx_sw_valid`, with `rx_sw_vrq` equal to its virtual receive queue. This holds whatever the hardware-queue index field of the entry contains.
- R7: While `rx_hw_valid` is high and bit `rx_hw_q` of `hwq_full` is 1, the message stays on the output unchanged and `rx_in_ready` is low. When the full bit clears, the next waiting input is accepted in that same cycle.
- R8: While `rx_sw_valid` is high and `rx_sw_ready` is low, the message stays on the output unchanged and `rx_in_ready` is low.
- R9: `rx_hw_valid` and `rx_sw_valid` are never high together.
- R10: A receive-table write in cycle N is not seen by an acceptance in cycle N but is seen by later ones, so remapping a queue redirects its later messages without any change at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_we | input | 1 | Transmit-table write strobe (privileged) |
| cfg_tx_addr | input | 9 | Transmit-table index to write |
| cfg_tx_valid | input | 1 | Valid bit to write |
| cfg_tx_node | input | 6 | Physical node to write |
| cfg_tx_vrq | input | 9 | Virtual receive queue to write |
| cfg_rx_we | input | 1 | Receive-table write strobe (privileged) |
| cfg_rx_addr | input | 9 | Receive-table index to write |
| cfg_rx_valid | input | 1 | Valid bit to write |
| cfg_rx_res | input | 1 | Resident bit to write |
| cfg_rx_hwq | input | 4 | Hardware-queue index to write |
| tx_in_valid | input | 1 | Transmit header present |
| tx_in_vdest | input | 9 | Virtual destination index |
| tx_in_tag | input | 16 | Header tag carried through |
| tx_out_valid | output | 1 | Translated header ready for injection |
| tx_err | output | 1 | Protection error, message dropped |
| tx_out_node | output | 6 | Physical destination node |
| tx_out_vrq | output | 9 | Virtual receive queue at the destination |
| tx_out_tag | output | 16 | Header tag |
| rx_in_valid | input | 1 | Received message present |
| rx_in_ready | output | 1 | Received message accepted this cycle |
| rx_in_vrq | input | 9 | Virtual receive queue of the received message |
| rx_in_tag | input | 16 | Received message tag |
| hwq_full | input | 16 | Full flag of each hardware queue |
| rx_hw_valid | output | 1 | Message steered to a hardware queue |
| rx_hw_q | output | 4 | Hardware-queue index |
| rx_sw_valid | output | 1 | Message diverted to the service processor |
| rx_sw_ready | input | 1 | Service-processor path can take the message |
| rx_sw_vrq | output | 9 | Virtual receive queue for the emulation path |
| rx_out_tag | output | 16 | Tag of the message on either output |

## Verification
Transmit lookups are run on valid entries with extreme node and queue values, including index 511 and the all-ones node, and on an invalid entry. These cases show the mapping path, field packing and error path apart. Receive lookups cover four kinds of entry: resident at the lowest and highest queue index, valid but not resident, and invalid with the resident bit set. They show whether steering depends on both bits and never on the stale index field. Writes issued in the same cycle as a lookup, on each table, separate the old data from the new. Stalls on a full hardware queue and on a withheld software ready, with a second message already waiting, check holding and the hand-over in the cycle the stall ends. A reset during a stall checks that the waiting message is discarded.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

  typedef enum logic {
    ROUTE_HW = 1'b0,
    ROUTE_SW = 1'b1
  } route_e;

  // Only a valid entry that is marked resident goes to hardware.
  function automatic route_e route_of(input logic ent_valid, input logic ent_res);
    return (ent_valid && ent_res) ? ROUTE_HW : ROUTE_SW;
  endfunction

endpackage

// File: rtl/msgq_tbl_ram.sv
module msgq_tbl_ram #(
  parameter int W  = 16,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  // Read-first: a read in the same cycle as a write returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/msgq_tx_xlate.sv
module msgq_tx_xlate #(
  parameter int VDEST_W = 9,
  parameter int NODE_W  = 6,
  parameter int VRQ_W   = 9,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [VDEST_W-1:0] cfg_addr,
  input  logic               cfg_valid,
  input  logic [NODE_W-1:0]  cfg_node,
  input  logic [VRQ_W-1:0]   cfg_vrq,
  input  logic               in_valid,
  input  logic [VDEST_W-1:0] in_vdest,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               out_valid,
  output logic               out_err,
  output logic [NODE_W-1:0]  out_node,
  output logic [VRQ_W-1:0]   out_vrq,
  output logic [TAG_W-1:0]   out_tag
);
  localparam int ENT_W = 1 + NODE_W + VRQ_W;

  logic [ENT_W-1:0] ent;
  logic             look_q;
  logic [TAG_W-1:0] tag_q;

  msgq_tbl_ram #(.W(ENT_W), .AW(VDEST_W)) u_tbl (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata ({cfg_valid, cfg_node, cfg_vrq}),
    .re    (in_valid),
    .raddr (in_vdest),
    .rdata (ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      look_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      look_q <= in_valid;
      if (in_valid) tag_q <= in_tag;
    end
  end

  assign out_valid = look_q &  ent[ENT_W-1];
  assign out_err   = look_q & ~ent[ENT_W-1];
  assign out_node  = ent[VRQ_W +: NODE_W];
  assign out_vrq   = ent[VRQ_W-1:0];
  assign out_tag   = tag_q;
endmodule

// File: rtl/msgq_rx_steer.sv
module msgq_rx_steer
  import msgq_pkg::*;
#(
  parameter int VRQ_W = 9,
  parameter int HWQ_N = 16,
  parameter int TAG_W = 16,
  localparam int HWQ_W = $clog2(HWQ_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [VRQ_W-1:0] cfg_addr,
  input  logic             cfg_valid,
  input  logic             cfg_res,
  input  logic [HWQ_W-1:0] cfg_hwq,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VRQ_W-1:0] in_vrq,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [HWQ_N-1:0] hwq_full,
  output logic             hw_valid,
  output logic [HWQ_W-1:0] hw_q,
  output logic             sw_valid,
  input  logic             sw_ready,
  output logic [VRQ_W-1:0] sw_vrq,
  output logic [TAG_W-1:0] out_tag
);
  localparam int ENT_W = 2 + HWQ_W;

  logic [ENT_W-1:0] ent;
  logic             stage_v;
  logic [VRQ_W-1:0] vrq_q;
  logic [TAG_W-1:0] tag_q;
  route_e           route;
  logic             drain;
  logic             accept;

  // The table output register is the stage's data register: it is read
  // only on acceptance, so it holds its word through a stall.
  msgq_tbl_ram #(.W(ENT_W), .AW(VRQ_W)) u_tbl (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata ({cfg_valid, cfg_res, cfg_hwq}),
    .re    (accept),
    .raddr (in_vrq),
    .rdata (ent)
  );

  always_comb begin
    route    = route_of(ent[ENT_W-1], ent[ENT_W-2]);
    drain    = stage_v && ((route == ROUTE_HW) ? !hwq_full[ent[HWQ_W-1:0]] : sw_ready);
    in_ready = !stage_v || drain;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= 1'b0;
      vrq_q   <= '0;
      tag_q   <= '0;
    end else begin
      if (accept) begin
        stage_v <= 1'b1;
        vrq_q   <= in_vrq;
        tag_q   <= in_tag;
      end else if (drain) begin
        stage_v <= 1'b0;
      end
    end
  end

  assign hw_valid = stage_v && (route == ROUTE_HW);
  assign sw_valid = stage_v && (route == ROUTE_SW);
  assign hw_q     = ent[HWQ_W-1:0];
  assign sw_vrq   = vrq_q;
  assign out_tag  = tag_q;
endmodule

// File: rtl/msgq_translate.sv
module msgq_translate #(
  parameter int VDEST_W = 9,
  parameter int NODE_W  = 6,
  parameter int VRQ_W   = 9,
  parameter int HWQ_N   = 16,
  parameter int TAG_W   = 16,
  localparam int HWQ_W  = $clog2(HWQ_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_tx_we,
  input  logic [VDEST_W-1:0] cfg_tx_addr,
  input  logic               cfg_tx_valid,
  input  logic [NODE_W-1:0]  cfg_tx_node,
  input  logic [VRQ_W-1:0]   cfg_tx_vrq,
  input  logic               cfg_rx_we,
  input  logic [VRQ_W-1:0]   cfg_rx_addr,
  input  logic               cfg_rx_valid,
  input  logic               cfg_rx_res,
  input  logic [HWQ_W-1:0]   cfg_rx_hwq,
  input  logic               tx_in_valid,
  input  logic [VDEST_W-1:0] tx_in_vdest,
  input  logic [TAG_W-1:0]   tx_in_tag,
  output logic               tx_out_valid,
  output logic               tx_err,
  output logic [NODE_W-1:0]  tx_out_node,
  output logic [VRQ_W-1:0]   tx_out_vrq,
  output logic [TAG_W-1:0]   tx_out_tag,
  input  logic               rx_in_valid,
  output logic               rx_in_ready,
  input  logic [VRQ_W-1:0]   rx_in_vrq,
  input  logic [TAG_W-1:0]   rx_in_tag,
  input  logic [HWQ_N-1:0]   hwq_full,
  output logic               rx_hw_valid,
  output logic [HWQ_W-1:0]   rx_hw_q,
  output logic               rx_sw_valid,
  input  logic               rx_sw_ready,
  output logic [VRQ_W-1:0]   rx_sw_vrq,
  output logic [TAG_W-1:0]   rx_out_tag
);

  msgq_tx_xlate #(
    .VDEST_W (VDEST_W),
    .NODE_W  (NODE_W),
    .VRQ_W   (VRQ_W),
    .TAG_W   (TAG_W)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_tx_we),
    .cfg_addr  (cfg_tx_addr),
    .cfg_valid (cfg_tx_valid),
    .cfg_node  (cfg_tx_node),
    .cfg_vrq   (cfg_tx_vrq),
    .in_valid  (tx_in_valid),
    .in_vdest  (tx_in_vdest),
    .in_tag    (tx_in_tag),
    .out_valid (tx_out_valid),
    .out_err   (tx_err),
    .out_node  (tx_out_node),
    .out_vrq   (tx_out_vrq),
    .out_tag   (tx_out_tag)
  );

  msgq_rx_steer #(
    .VRQ_W (VRQ_W),
    .HWQ_N (HWQ_N),
    .TAG_W (TAG_W)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_rx_we),
    .cfg_addr  (cfg_rx_addr),
    .cfg_valid (cfg_rx_valid),
    .cfg_res   (cfg_rx_res),
    .cfg_hwq   (cfg_rx_hwq),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_vrq    (rx_in_vrq),
    .in_tag    (rx_in_tag),
    .hwq_full  (hwq_full),
    .hw_valid  (rx_hw_valid),
    .hw_q      (rx_hw_q),
    .sw_valid  (rx_sw_valid),
    .sw_ready  (rx_sw_ready),
    .sw_vrq    (rx_sw_vrq),
    .out_tag   (rx_out_tag)
  );
endmodule

// File: rtl/msgq_translate_chk.sv
module msgq_translate_chk #(
  parameter int VDEST_W = 9,
  parameter int NODE_W  = 6,
  parameter int VRQ_W   = 9,
  parameter int HWQ_N   = 16,
  parameter int TAG_W   = 16,
  localparam int HWQ_W  = $clog2(HWQ_N)
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_in_valid,
  input logic [TAG_W-1:0] tx_in_tag,
  input logic             tx_out_valid,
  input logic             tx_err,
  input logic [TAG_W-1:0] tx_out_tag,
  input logic             rx_in_ready,
  input logic [HWQ_N-1:0] hwq_full,
  input logic             rx_hw_valid,
  input logic [HWQ_W-1:0] rx_hw_q,
  input logic             rx_sw_valid,
  input logic             rx_sw_ready,
  input logic [VRQ_W-1:0] rx_sw_vrq,
  input logic [TAG_W-1:0] rx_out_tag
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tx_out_valid && !tx_err && !rx_hw_valid && !rx_sw_valid && rx_in_ready)); // R1

  AST_TX_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid || tx_err) |-> $past(tx_in_valid)); // R2

  AST_TX_TAG_CARRIED: assert property (@(posedge clk) disable iff (rst)
    tx_out_valid |-> (tx_out_tag == $past(tx_in_tag))); // R2

  AST_TX_ERR_DROPS: assert property (@(posedge clk) disable iff (rst)
    !(tx_out_valid && tx_err)); // R3

  AST_HW_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_hw_valid && hwq_full[rx_hw_q]) |=>
      (rx_hw_valid && $stable(rx_hw_q) && $stable(rx_out_tag))); // R7

  AST_HW_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (rx_hw_valid && hwq_full[rx_hw_q]) |-> !rx_in_ready); // R7

  AST_SW_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_sw_valid && !rx_sw_ready) |=>
      (rx_sw_valid && $stable(rx_sw_vrq) && $stable(rx_out_tag))); // R8

  AST_SW_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (rx_sw_valid && !rx_sw_ready) |-> !rx_in_ready); // R8

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_hw_valid, rx_sw_valid})); // R9

endmodule

bind msgq_translate msgq_translate_chk #(
  .VDEST_W (VDEST_W),
  .NODE_W  (NODE_W),
  .VRQ_W   (VRQ_W),
  .HWQ_N   (HWQ_N),
  .TAG_W   (TAG_W)
) u_msgq_translate_chk (.*);

// File: tb/test_msgq_translate.sv
module test_msgq_translate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_tx_we = 1'b0;
  logic [8:0]  cfg_tx_addr = '0;
  logic        cfg_tx_valid = 1'b0;
  logic [5:0]  cfg_tx_node = '0;
  logic [8:0]  cfg_tx_vrq = '0;
  logic        cfg_rx_we = 1'b0;
  logic [8:0]  cfg_rx_addr = '0;
  logic        cfg_rx_valid = 1'b0;
  logic        cfg_rx_res = 1'b0;
  logic [3:0]  cfg_rx_hwq = '0;
  logic        tx_in_valid = 1'b0;
  logic [8:0]  tx_in_vdest = '0;
  logic [15:0] tx_in_tag = '0;
  logic        tx_out_valid, tx_err;
  logic [5:0]  tx_out_node;
  logic [8:0]  tx_out_vrq;
  logic [15:0] tx_out_tag;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [8:0]  rx_in_vrq = '0;
  logic [15:0] rx_in_tag = '0;
  logic [15:0] hwq_full = '0;
  logic        rx_hw_valid;
  logic [3:0]  rx_hw_q;
  logic        rx_sw_valid;
  logic        rx_sw_ready = 1'b1;
  logic [8:0]  rx_sw_vrq;
  logic [15:0] rx_out_tag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  msgq_translate i_msgq_translate (.*);

  // {is_rx, index, expect_ok/resident, x: node or hw queue, y: vrq}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 9'd3,   1'b1, 9'd5,  9'd100},
    {1'b0, 9'd7,   1'b1, 9'd63, 9'd511},
    {1'b0, 9'd10,  1'b0, 9'd0,  9'd0},
    {1'b0, 9'd511, 1'b1, 9'd0,  9'd0},
    {1'b1, 9'd100, 1'b1, 9'd2,  9'd100},
    {1'b1, 9'd200, 1'b1, 9'd15, 9'd200},
    {1'b1, 9'd300, 1'b0, 9'd0,  9'd300},
    {1'b1, 9'd400, 1'b0, 9'd0,  9'd400},
    {1'b1, 9'd0,   1'b1, 9'd0,  9'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_tx(input int a, input bit v, input int node, input int vrq);
    cfg_tx_we = 1'b1; cfg_tx_addr = 9'(a); cfg_tx_valid = v;
    cfg_tx_node = 6'(node); cfg_tx_vrq = 9'(vrq);
    @(negedge clk);
    cfg_tx_we = 1'b0;
  endtask

  task automatic wr_rx(input int a, input bit v, input bit res, input int q);
    cfg_rx_we = 1'b1; cfg_rx_addr = 9'(a); cfg_rx_valid = v;
    cfg_rx_res = res; cfg_rx_hwq = 4'(q);
    @(negedge clk);
    cfg_rx_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held while reset is high
    chk("R1", "tx_out_valid in reset", int'(tx_out_valid), 0);
    chk("R1", "rx_hw_valid in reset", int'(rx_hw_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "tx_err after reset", int'(tx_err), 0);
    chk("R1", "rx_sw_valid after reset", int'(rx_sw_valid), 0);
    chk("R1", "rx_in_ready after reset", int'(rx_in_ready), 1);

    wr_tx(3, 1, 5, 100);
    wr_tx(7, 1, 63, 511);
    wr_tx(10, 0, 12, 12);
    wr_tx(511, 1, 0, 0);
    wr_tx(20, 0, 0, 0);
    wr_rx(100, 1, 1, 2);
    wr_rx(200, 1, 1, 15);
    wr_rx(300, 1, 0, 7);
    wr_rx(400, 0, 1, 4);
    wr_rx(0, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      if (!v[28]) begin
        tx_in_valid = 1'b1; tx_in_vdest = v[27:19]; tx_in_tag = 16'(16'h1000 + i);
        @(negedge clk);
        tx_in_valid = 1'b0;
        if (v[18]) begin
          chk("R2", "tx_out_valid", int'(tx_out_valid), 1);
          chk("R2", "tx_out_node", int'(tx_out_node), int'(v[17:9]));
          chk("R2", "tx_out_vrq", int'(tx_out_vrq), int'(v[8:0]));
          chk("R2", "tx_out_tag", int'(tx_out_tag), 16'h1000 + i);
          chk("R3", "tx_err on valid entry", int'(tx_err), 0);
        end else begin
          chk("R3", "tx_err", int'(tx_err), 1);
          chk("R3", "tx_out_valid on invalid", int'(tx_out_valid), 0);
        end
        @(negedge clk);
        chk("R3", "tx_err is a single pulse", int'(tx_err), 0);
      end else begin
        rx_in_valid = 1'b1; rx_in_vrq = v[27:19]; rx_in_tag = 16'(16'h2000 + i);
        @(negedge clk);
        rx_in_valid = 1'b0;
        if (v[18]) begin
          chk("R5", "rx_hw_valid", int'(rx_hw_valid), 1);
          chk("R5", "rx_hw_q", int'(rx_hw_q), int'(v[17:9]));
          chk("R5", "rx_out_tag", int'(rx_out_tag), 16'h2000 + i);
          chk("R9", "rx_sw_valid on resident", int'(rx_sw_valid), 0);
        end else begin
          chk("R6", "rx_sw_valid", int'(rx_sw_valid), 1);
          chk("R6", "rx_sw_vrq", int'(rx_sw_vrq), int'(v[8:0]));
          chk("R6", "rx_hw_valid on non-resident", int'(rx_hw_valid), 0);
        end
        @(negedge clk);
      end
    end

    // R4: write and lookup in the same cycle sees the old entry
    cfg_tx_we = 1'b1; cfg_tx_addr = 9'd20; cfg_tx_valid = 1'b1;
    cfg_tx_node = 6'd9; cfg_tx_vrq = 9'd33;
    tx_in_valid = 1'b1; tx_in_vdest = 9'd20; tx_in_tag = 16'h3000;
    @(negedge clk);
    cfg_tx_we = 1'b0;
    chk("R4", "same-cycle lookup sees old (err)", int'(tx_err), 1);
    tx_in_tag = 16'h3001;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R4", "next lookup valid", int'(tx_out_valid), 1);
    chk("R4", "next lookup node", int'(tx_out_node), 9);
    chk("R4", "next lookup vrq", int'(tx_out_vrq), 33);

    // R7: stall on full hardware queue 2, second message waiting
    hwq_full = 16'h0004;
    rx_in_valid = 1'b1; rx_in_vrq = 9'd100; rx_in_tag = 16'hAAAA;
    @(negedge clk);
    chk("R7", "hw valid while full", int'(rx_hw_valid), 1);
    chk("R7", "in_ready low while full", int'(rx_in_ready), 0);
    rx_in_vrq = 9'd300; rx_in_tag = 16'hBBBB;
    repeat (3) @(negedge clk);
    chk("R7", "hw valid held", int'(rx_hw_valid), 1);
    chk("R7", "hw tag held", int'(rx_out_tag), 16'hAAAA);
    chk("R7", "hw queue held", int'(rx_hw_q), 2);
    hwq_full = 16'h0000;
    @(negedge clk);
    rx_in_valid = 1'b0;
    rx_sw_ready = 1'b0;
    chk("R7", "waiting message taken on release", int'(rx_sw_valid), 1);
    chk("R7", "waiting message tag", int'(rx_out_tag), 16'hBBBB);
    chk("R9", "hw valid cleared on hand-over", int'(rx_hw_valid), 0);

    // R8: software path withholds ready
    repeat (2) @(negedge clk);
    chk("R8", "sw valid held", int'(rx_sw_valid), 1);
    chk("R8", "sw vrq held", int'(rx_sw_vrq), 300);
    chk("R8", "in_ready low while sw stalls", int'(rx_in_ready), 0);
    rx_sw_ready = 1'b1;
    @(negedge clk);
    chk("R8", "sw drained after ready", int'(rx_sw_valid), 0);

    // R1: reset discards a stalled message
    hwq_full = 16'h8000;
    rx_in_valid = 1'b1; rx_in_vrq = 9'd200; rx_in_tag = 16'hCCCC;
    @(negedge clk);
    rx_in_valid = 1'b0;
    chk("R1", "stalled hw message present", int'(rx_hw_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hwq_full = 16'h0000;
    chk("R1", "reset discards stalled message", int'(rx_hw_valid), 0);
    chk("R1", "rx_in_ready after mid reset", int'(rx_in_ready), 1);

    // R10: remap queue 100 to software in the same cycle as an acceptance
    cfg_rx_we = 1'b1; cfg_rx_addr = 9'd100; cfg_rx_valid = 1'b1;
    cfg_rx_res = 1'b0; cfg_rx_hwq = 4'd2;
    rx_in_valid = 1'b1; rx_in_vrq = 9'd100; rx_in_tag = 16'hD000;
    @(negedge clk);
    cfg_rx_we = 1'b0;
    rx_in_tag = 16'hD001;
    chk("R10", "same-cycle acceptance uses old entry", int'(rx_hw_valid), 1);
    @(negedge clk);
    rx_in_valid = 1'b0;
    chk("R10", "later message diverted to sw", int'(rx_sw_valid), 1);
    chk("R10", "diverted vrq", int'(rx_sw_vrq), 100);
    chk("R10", "diverted tag", int'(rx_out_tag), 16'hD001);
    @(negedge clk);

    finish_run();
  end
endmodule